// File: doc/BRIEF.md
# Multichannel DAC Serial Command Decoder

This block is the digital front end of a sixteen-channel digital-to-analog converter. It acts as the target of a serial bus with a chip select. Each transaction carries a command byte followed by a 16-bit data word. The decoder checks that the frame has exactly the right length, splits the command byte into an operation nibble and a channel nibble, and updates its register set.

The register set holds a per-channel input (staging) register and a per-channel output code register. It also holds an output-range code, a per-channel dither power-down mask, a per-channel dither polarity mask, and two 32-bit fields that carry a 2-bit dither source and a 2-bit dither scale for each channel. All output codes and control fields are presented as parallel outputs, where the analog side reads them directly.

Some operations take their channel from the low nibble of the command byte. Others are single fixed byte values, and any other low nibble with those operation nibbles is ignored. A readback takes two transactions: the first one names the channel, and the code is shifted out on the serial output during the next one. A full clear is accepted only when it carries a key word. A build parameter sets the converter resolution below 16 bits, and the unused low bits of each code then read as zero.

Top module: `dac_cmd_decoder`

## Requirements
- R1: After a synchronous active-low reset, the registers hold these values: every input register and output code is 0, the range code is 0, the dither power-down mask is 16'hFFFF, and the dither source, scale and polarity fields are 0. `miso` is low.
- R2: A frame is the span while `cs_n` is low. `mosi` is sampled on each rising `sclk`, most significant bit first: the command byte comes first, then the data word. The decoded effect appears in the clock cycle after the cycle in which `cs_n` is seen high again. No register output changes while `cs_n` stays low.
- R3: A frame that ends with a bit count other than 24 changes no register and does not arm a readback.
- R4: Command 0x1n loads channel n's input register without touching its output code. Command 0x30 copies every input register into its channel's output code in one cycle.
- R5: Command 0x2n writes the data word into channel n's output code. Command 0x60 writes the data word into every channel's output code.
- R6: Command 0x40 loads the 3-bit range code from data bits 2:0.
- R7: Command 0x51 loads the dither power-down mask, and command 0xB0 loads the dither polarity mask. In both masks, bit n belongs to channel n. In the power-down mask, a 1 powers the channel's dither down.
- R8: Commands 0x90 and 0xA0 load bits 15:0 and 31:16 of the dither source field. Commands 0xC0 and 0xD0 do the same for the dither scale field. Channel n owns bits 2n+1:2n of each field. Scale codes 0 to 3 mean 100, 75, 50 and 25 percent.
- R9: Some command bytes change no state: 0x00, 0x01, a fixed-code operation nibble (3, 4, 5, 6, 7, 9 to D) with any other low nibble, and operation nibbles E and F.
- R10: Command 0x70 with data 16'h1234 returns every register to its R1 value and cancels an armed readback. With any other data, 0x70 is ignored.
- R11: A valid 0x8n frame arms a readback of channel n's output code. During the next frame only, `miso` presents that code most significant bit first. Bit k is valid before the k-th rising `sclk` and advances on each falling `sclk`. Zeros follow the code. Frames with no readback armed shift out zeros. `miso` is low while `cs_n` is high.
- R12: With RES_BITS below 16, each code written is left-aligned and its low 16-RES_BITS bits are stored as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial inputs are assumed synchronous to it |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial bit clock, idle low |
| cs_n | input | 1 | Frame select, active low |
| mosi | input | 1 | Serial command and data in |
| miso | output | 1 | Serial readback out |
| dac_codes | output | NUM_CH*16 | Output code of channel n at bits 16n+15:16n |
| span_code | output | 3 | Output-range code |
| dither_pd | output | 16 | Dither power-down mask, one bit per channel |
| dither_src | output | 32 | Dither source select, 2 bits per channel |
| dither_scale | output | 32 | Dither scale code, 2 bits per channel |
| dither_inv | output | 16 | Dither polarity invert mask, one bit per channel |

## Verification
The decoder is driven with four kinds of input. Banked commands are sent to different channel nibbles, which tells a correct channel select from a stuck or misrouted one. Fixed commands are sent both with their exact byte and with stray low nibbles, which separates full-byte matching from matching on the operation nibble alone. Frames of 23 and 25 bits are sent next to 24-bit frames, to show that the length check rejects both shorter and longer frames. Readback is exercised by an armed frame, an unarmed frame and an armed-by-short-frame case, which shows that the serial output is one-shot and follows the named channel. The key word for the full clear is sent both off by one and exact.

// File: rtl/dac_cmd_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the decoded-command record used between
// the command decoder and the register bank.
package dac_cmd_pkg;

    localparam int          CMD_W     = 8;
    localparam int          WORD_W    = 16;
    localparam logic [15:0] CLEAR_KEY = 16'h1234;

    // Fixed full-byte command codes
    localparam logic [7:0] C_LOAD_ALL = 8'h30;
    localparam logic [7:0] C_RANGE    = 8'h40;
    localparam logic [7:0] C_DPWR     = 8'h51;
    localparam logic [7:0] C_WR_ALL   = 8'h60;
    localparam logic [7:0] C_CLEAR    = 8'h70;
    localparam logic [7:0] C_DSRC_LO  = 8'h90;
    localparam logic [7:0] C_DSRC_HI  = 8'hA0;
    localparam logic [7:0] C_DINV     = 8'hB0;
    localparam logic [7:0] C_DSCL_LO  = 8'hC0;
    localparam logic [7:0] C_DSCL_HI  = 8'hD0;

    // Banked operation nibbles (low nibble is the channel)
    localparam logic [3:0] N_WR_IN  = 4'h1;
    localparam logic [3:0] N_WR_OUT = 4'h2;
    localparam logic [3:0] N_RDBK   = 4'h8;

    typedef struct packed {
        logic       wr_in;
        logic       wr_out;
        logic       load_all;
        logic       wr_all;
        logic       range;
        logic       dpwr;
        logic       dinv;
        logic       dsrc_lo;
        logic       dsrc_hi;
        logic       dscl_lo;
        logic       dscl_hi;
        logic       clear;
        logic       rdbk;
        logic [3:0] ch;
    } op_t;

endpackage

// File: rtl/dac_spi_frame.sv
`timescale 1ns/1ps
// Serial framer: samples mosi on rising sclk while cs_n is low, counts bits
// with saturation, and flags a frame as good only if exactly FRAME_BITS were
// seen when cs_n returns high. A readback word is loaded into the shifter as
// the frame opens and shifted on falling sclk.
// Assumes sclk, cs_n and mosi are already synchronous to clk and that sclk
// is low whenever cs_n changes.
module dac_spi_frame #(
    parameter int FRAME_BITS = 24,
    parameter int WORD_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic [WORD_W-1:0] tx_word,
    output logic              miso,
    output logic              frame_start,
    output logic              frame_ok,
    output logic [7:0]        cmd,
    output logic [WORD_W-1:0] data
);
    localparam int                CNT_W    = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0]  CNT_SAT  = '1;
    localparam int                PAD_W    = FRAME_BITS - WORD_W;

    logic                  sclk_q, cs_q;
    logic [CNT_W-1:0]      cnt;
    logic [FRAME_BITS-1:0] rx_sh, tx_sh;
    logic                  sclk_rise, sclk_fall, frame_end;

    // Edge detection on the registered copies of the serial controls
    assign sclk_rise   = sclk  & ~sclk_q & ~cs_n;
    assign sclk_fall   = ~sclk &  sclk_q & ~cs_n;
    assign frame_start = ~cs_n &  cs_q;
    assign frame_end   =  cs_n & ~cs_q;

    // Bit capture, bit count and readback shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
            cnt    <= '0;
            rx_sh  <= '0;
            tx_sh  <= '0;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
            if (frame_start) begin
                cnt   <= '0;
                tx_sh <= {tx_word, {PAD_W{1'b0}}};
            end else begin
                if (sclk_rise) begin
                    rx_sh <= {rx_sh[FRAME_BITS-2:0], mosi};
                    if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
                end
                if (sclk_fall) tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b0};
            end
        end
    end

    assign frame_ok = frame_end && (cnt == CNT_FULL);
    assign cmd      = rx_sh[FRAME_BITS-1 -: 8];
    assign data     = rx_sh[WORD_W-1:0];
    assign miso     = ~cs_n & tx_sh[FRAME_BITS-1];

endmodule

// File: rtl/dac_cmd_decode.sv
`timescale 1ns/1ps
// Command decoder: turns the command byte into one-hot operation flags.
// Banked operations match on the upper nibble only; fixed operations match
// the whole byte. The clear flag is raised only with the key data word.
// Purely combinational; its flags are qualified by frame_ok downstream.
module dac_cmd_decode
    import dac_cmd_pkg::*;
(
    input  logic [7:0]  cmd,
    input  logic [15:0] data,
    output op_t         op
);
    // Decode banked nibbles, then exact fixed codes
    always_comb begin
        op    = '0;
        op.ch = cmd[3:0];
        case (cmd[7:4])
            N_WR_IN:  op.wr_in  = 1'b1;
            N_WR_OUT: op.wr_out = 1'b1;
            N_RDBK:   op.rdbk   = 1'b1;
            default:  ;
        endcase
        case (cmd)
            C_LOAD_ALL: op.load_all = 1'b1;
            C_RANGE:    op.range    = 1'b1;
            C_DPWR:     op.dpwr     = 1'b1;
            C_WR_ALL:   op.wr_all   = 1'b1;
            C_CLEAR:    op.clear    = (data == CLEAR_KEY);
            C_DSRC_LO:  op.dsrc_lo  = 1'b1;
            C_DSRC_HI:  op.dsrc_hi  = 1'b1;
            C_DINV:     op.dinv     = 1'b1;
            C_DSCL_LO:  op.dscl_lo  = 1'b1;
            C_DSCL_HI:  op.dscl_hi  = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/dac_reg_bank.sv
`timescale 1ns/1ps
// Register bank: per-channel input and output code registers plus the
// range and dither controls. Updates only on a good frame. Also holds the
// one-shot readback selection consumed when the next frame opens.
// Assumes NUM_CH <= 16 (the channel field is one nibble).
module dac_reg_bank
    import dac_cmd_pkg::*;
#(
    parameter int NUM_CH   = 16,
    parameter int RES_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_ok,
    input  logic                 frame_start,
    input  op_t                  op,
    input  logic [15:0]          data,
    output logic [NUM_CH*16-1:0] dac_flat,
    output logic [2:0]           span_code,
    output logic [15:0]          dither_pd,
    output logic [31:0]          dither_src,
    output logic [31:0]          dither_scale,
    output logic [15:0]          dither_inv,
    output logic [15:0]          rb_word
);
    localparam int          PAD       = 16 - RES_BITS;
    localparam logic [15:0] CODE_MASK = 16'(16'hFFFF << PAD);

    logic [NUM_CH-1:0][15:0] in_arr, out_arr;
    logic [15:0]             code_w;
    logic                    wipe;
    logic                    rb_armed;
    logic [3:0]              rb_ch;

    assign code_w = data & CODE_MASK;
    assign wipe   = frame_ok && op.clear;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [3:0] CH_ID = 4'(g);
        logic [15:0] in_q, out_q;
        logic        hit;
        assign hit = (op.ch == CH_ID);

        // Per-channel staging and output code update
        always_ff @(posedge clk) begin
            if (!rst_n || wipe) begin
                in_q  <= '0;
                out_q <= '0;
            end else if (frame_ok) begin
                if (op.wr_in && hit) in_q <= code_w;
                if (op.wr_out && hit)  out_q <= code_w;
                else if (op.wr_all)    out_q <= code_w;
                else if (op.load_all)  out_q <= in_q;
            end
        end

        assign in_arr[g]  = in_q;
        assign out_arr[g] = out_q;
    end

    // Range and dither control registers
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            span_code    <= '0;
            dither_pd    <= 16'hFFFF;
            dither_src   <= '0;
            dither_scale <= '0;
            dither_inv   <= '0;
        end else if (frame_ok) begin
            if (op.range)   span_code           <= data[2:0];
            if (op.dpwr)    dither_pd           <= data;
            if (op.dinv)    dither_inv          <= data;
            if (op.dsrc_lo) dither_src[15:0]    <= data;
            if (op.dsrc_hi) dither_src[31:16]   <= data;
            if (op.dscl_lo) dither_scale[15:0]  <= data;
            if (op.dscl_hi) dither_scale[31:16] <= data;
        end
    end

    // One-shot readback arming; disarmed as the next frame opens
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            rb_armed <= 1'b0;
            rb_ch    <= '0;
        end else if (frame_ok && op.rdbk) begin
            rb_armed <= 1'b1;
            rb_ch    <= op.ch;
        end else if (frame_start) begin
            rb_armed <= 1'b0;
        end
    end

    assign rb_word  = rb_armed ? out_arr[rb_ch] : '0;
    assign dac_flat = out_arr;

    // Input registers are only observable through load-all
    logic unused_in;
    assign unused_in = ^in_arr;

endmodule

// File: rtl/dac_cmd_decoder.sv
`timescale 1ns/1ps
// Top: serial command decoder for a multichannel DAC. Connects framer,
// command decoder and register bank. Serial inputs must be synchronous
// to clk; reset is synchronous and active low.
module dac_cmd_decoder
    import dac_cmd_pkg::*;
#(
    parameter int NUM_CH     = 16,
    parameter int RES_BITS   = 16,
    parameter int FRAME_BITS = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk,
    input  logic                 cs_n,
    input  logic                 mosi,
    output logic                 miso,
    output logic [NUM_CH*16-1:0] dac_codes,
    output logic [2:0]           span_code,
    output logic [15:0]          dither_pd,
    output logic [31:0]          dither_src,
    output logic [31:0]          dither_scale,
    output logic [15:0]          dither_inv
);
    logic        frame_start, frame_ok;
    logic [7:0]  cmd;
    logic [15:0] data, rb_word;
    op_t         op;

    dac_spi_frame #(.FRAME_BITS(FRAME_BITS), .WORD_W(WORD_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .tx_word(rb_word), .miso(miso), .frame_start(frame_start),
        .frame_ok(frame_ok), .cmd(cmd), .data(data)
    );

    dac_cmd_decode u_dec (
        .cmd(cmd), .data(data), .op(op)
    );

    dac_reg_bank #(.NUM_CH(NUM_CH), .RES_BITS(RES_BITS)) u_bank (
        .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok),
        .frame_start(frame_start), .op(op), .data(data),
        .dac_flat(dac_codes), .span_code(span_code), .dither_pd(dither_pd),
        .dither_src(dither_src), .dither_scale(dither_scale),
        .dither_inv(dither_inv), .rb_word(rb_word)
    );

endmodule

// File: rtl/dac_cmd_decoder_chk.sv
`timescale 1ns/1ps
// Checker: temporal properties at the top-level ports of dac_cmd_decoder.
module dac_cmd_decoder_chk #(
    parameter int NUM_CH = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sclk,
    input logic                 cs_n,
    input logic                 miso,
    input logic [NUM_CH*16-1:0] dac_codes,
    input logic [2:0]           span_code,
    input logic [15:0]          dither_pd,
    input logic [31:0]          dither_src,
    input logic [31:0]          dither_scale,
    input logic [15:0]          dither_inv
);
    // R1: first cycle out of reset shows the reset values
    a_r1_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (dac_codes == '0 && span_code == 3'd0 &&
                           dither_pd == 16'hFFFF && dither_src == '0 &&
                           dither_scale == '0 && dither_inv == '0));

    // R2: output codes move only right after cs_n has gone high
    a_r2_dac_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(dac_codes)) |->
            ($past(cs_n) && !$past(cs_n, 2)));

    // R2: control fields move only right after cs_n has gone high
    a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable({span_code, dither_pd, dither_src,
                                   dither_scale, dither_inv})) |->
            ($past(cs_n) && !$past(cs_n, 2)));

    // R11: miso changes only on a select change or after a falling sclk
    a_r11_miso_moves: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && !$stable(miso)) |->
            (!$stable(cs_n) || ($past(cs_n) != $past(cs_n, 2)) ||
             ($past(sclk, 2) && !$past(sclk))));

endmodule

bind dac_cmd_decoder dac_cmd_decoder_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .miso(miso),
    .dac_codes(dac_codes), .span_code(span_code), .dither_pd(dither_pd),
    .dither_src(dither_src), .dither_scale(dither_scale),
    .dither_inv(dither_inv)
);

// File: tb/dac_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural register model, compared every clock, plus directed
// checks per requirement. A 12-bit instance shares the serial inputs.
module dac_cmd_decoder_tb_top;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, miso12;
    logic [255:0] codes, codes12;
    logic [2:0]   span, span12;
    logic [15:0]  pd, pd12, inv, inv12;
    logic [31:0]  src, src12, scl, scl12;

    int total = 0, bad = 0;
    bit cmp_en = 0, done = 0;

    always #4 clk = ~clk;

    dac_cmd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .dac_codes(codes), .span_code(span), .dither_pd(pd),
        .dither_src(src), .dither_scale(scl), .dither_inv(inv));

    dac_cmd_decoder #(.RES_BITS(12)) dut12_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso12), .dac_codes(codes12), .span_code(span12),
        .dither_pd(pd12), .dither_src(src12), .dither_scale(scl12),
        .dither_inv(inv12));

    // Reference model state
    logic [15:0] m_in [16];
    logic [15:0] m_out[16];
    logic [2:0]  m_span;
    logic [15:0] m_pd, m_inv;
    logic [31:0] m_src, m_scl;
    bit          m_arm;
    int          m_rbch;

    task automatic chk(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic m_clear();
        foreach (m_in[i]) begin m_in[i] = '0; m_out[i] = '0; end
        m_span = '0; m_pd = 16'hFFFF; m_inv = '0; m_src = '0; m_scl = '0;
        m_arm = 0; m_rbch = 0;
    endtask

    task automatic m_apply(input logic [7:0] c, input logic [15:0] d);
        int n = int'(c[3:0]);
        case (c[7:4])
            4'h1: m_in[n]  = d;
            4'h2: m_out[n] = d;
            4'h8: begin m_arm = 1; m_rbch = n; end
            default: ;
        endcase
        case (c)
            8'h30: for (int i = 0; i < 16; i++) m_out[i] = m_in[i];
            8'h40: m_span = d[2:0];
            8'h51: m_pd = d;
            8'h60: for (int i = 0; i < 16; i++) m_out[i] = d;
            8'h70: if (d == 16'h1234) m_clear();
            8'h90: m_src[15:0]  = d;
            8'hA0: m_src[31:16] = d;
            8'hB0: m_inv = d;
            8'hC0: m_scl[15:0]  = d;
            8'hD0: m_scl[31:16] = d;
            default: ;
        endcase
    endtask

    // Every-clock comparison against the model (R2, R12)
    always @(negedge clk) begin
        if (cmp_en) begin
            for (int i = 0; i < 16; i++) begin
                chk("R2 code", 32'(codes[16*i +: 16]), 32'(m_out[i]));
                chk("R12 code12", 32'(codes12[16*i +: 16]),
                    32'(m_out[i] & 16'hFFF0));
            end
            chk("R2 span", 32'(span), 32'(m_span));
            chk("R2 dpwr", 32'(pd), 32'(m_pd));
            chk("R2 dinv", 32'(inv), 32'(m_inv));
            chk("R2 dsrc", src, m_src);
            chk("R2 dscl", scl, m_scl);
            if (cs_n) chk("R11 idle miso", 32'(miso), 32'd0);
        end
    end

    // One frame of nbits; checks miso per bit and returns captured word
    task automatic send(input int nbits, input logic [7:0] c,
                        input logic [15:0] d, output logic [15:0] rx);
        logic [23:0] w = {c, d};
        logic [15:0] exp_tx = m_arm ? m_out[m_rbch] : 16'h0;
        m_arm = 0;
        rx = '0;
        cs_n = 1'b0;
        @(negedge clk); @(negedge clk);
        for (int k = 0; k < nbits; k++) begin
            mosi = (k < 24) ? w[23-k] : 1'b0;
            @(negedge clk);
            chk("R11 miso bit", 32'(miso), (k < 16) ? 32'(exp_tx[15-k]) : 32'd0);
            if (k < 16) rx[15-k] = miso;
            sclk = 1'b1;
            @(negedge clk); @(negedge clk);
            sclk = 1'b0;
            @(negedge clk);
        end
        cs_n = 1'b1;
        @(posedge clk);
        if (nbits == 24) m_apply(c, d);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] c, input logic [15:0] d);
        logic [15:0] rx;
        send(24, c, d, rx);
    endtask

    function automatic logic [15:0] code_of(input int ch);
        return codes[16*ch +: 16];
    endfunction

    initial begin
        logic [15:0] rx;
        logic [255:0] snap;
        m_clear();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_en = 1;
        // R1 reset state
        chk("R1 codes", 32'(codes == '0), 32'd1);
        chk("R1 dpwr", 32'(pd), 32'hFFFF);
        chk("R1 span", 32'(span), 32'd0);
        chk("R1 miso", 32'(miso), 32'd0);

        // R5 direct write, banked by channel
        wr(8'h23, 16'hBEEF);
        chk("R5 ch3", 32'(code_of(3)), 32'hBEEF);
        chk("R5 ch2", 32'(code_of(2)), 32'h0);
        // R4 staged write then load-all
        wr(8'h15, 16'h1357);
        chk("R4 staged hidden", 32'(code_of(5)), 32'h0);
        wr(8'h30, 16'h0000);
        chk("R4 load ch5", 32'(code_of(5)), 32'h1357);
        chk("R4 load ch3", 32'(code_of(3)), 32'h0);
        // R5 write-all
        wr(8'h60, 16'hA5A5);
        chk("R5 all ch0", 32'(code_of(0)), 32'hA5A5);
        chk("R5 all ch15", 32'(code_of(15)), 32'hA5A5);
        wr(8'h2F, 16'h0001);
        chk("R5 ch15", 32'(code_of(15)), 32'h0001);
        // R6 range
        wr(8'h40, 16'hFFFD);
        chk("R6 span", 32'(span), 32'd5);
        // R7 masks
        wr(8'h51, 16'h00F0);
        chk("R7 dpwr", 32'(pd), 32'h00F0);
        wr(8'hB0, 16'h8001);
        chk("R7 dinv", 32'(inv), 32'h8001);
        // R8 split fields
        wr(8'h90, 16'h5555);
        wr(8'hA0, 16'hCDEF);
        chk("R8 dsrc", src, 32'hCDEF5555);
        wr(8'hD0, 16'h00E4);
        chk("R8 dscl hi", scl, 32'h00E40000);
        wr(8'hC0, 16'h1B1B);
        chk("R8 dscl", scl, 32'h00E41B1B);

        // R9 ignored codes
        snap = codes;
        wr(8'h31, 16'h0000); wr(8'h50, 16'hFFFF); wr(8'h52, 16'h0F0F);
        wr(8'h61, 16'h7777); wr(8'h41, 16'h0007); wr(8'hE0, 16'h1111);
        wr(8'hF3, 16'h2222); wr(8'h00, 16'h3333); wr(8'h01, 16'h4444);
        wr(8'h91, 16'h6666); wr(8'hB2, 16'hFFFF);
        chk("R9 codes", 32'(codes == snap), 32'd1);
        chk("R9 span", 32'(span), 32'd5);
        chk("R9 dpwr", 32'(pd), 32'h00F0);

        // R3 wrong-length frames
        send(23, 8'h21, 16'h9999, rx);
        chk("R3 short", 32'(code_of(1)), 32'hA5A5);
        send(25, 8'h21, 16'h9999, rx);
        chk("R3 long", 32'(code_of(1)), 32'hA5A5);

        // R11 readback, one-shot
        wr(8'h27, 16'h6C3A);
        wr(8'h87, 16'h0000);
        send(24, 8'h00, 16'h0000, rx);
        chk("R11 readback", 32'(rx), 32'h6C3A);
        send(24, 8'h00, 16'h0000, rx);
        chk("R11 unarmed", 32'(rx), 32'h0);
        wr(8'h8F, 16'h0000);
        send(24, 8'h00, 16'h0000, rx);
        chk("R11 ch15", 32'(rx), 32'h0001);
        send(20, 8'h87, 16'h0000, rx);
        send(24, 8'h00, 16'h0000, rx);
        chk("R3 short readback", 32'(rx), 32'h0);

        // R12 reduced resolution
        wr(8'h2B, 16'hFFFF);
        chk("R12 full", 32'(code_of(11)), 32'hFFFF);
        chk("R12 masked", 32'(codes12[16*11 +: 16]), 32'hFFF0);

        // R10 keyed clear
        wr(8'h88, 16'h0000);
        wr(8'h70, 16'h1233);
        chk("R10 bad key", 32'(pd), 32'h00F0);
        wr(8'h70, 16'h1234);
        chk("R10 codes", 32'(codes == '0), 32'd1);
        chk("R10 dpwr", 32'(pd), 32'hFFFF);
        chk("R10 dsrc", src, 32'h0);
        send(24, 8'h00, 16'h0000, rx);
        chk("R10 rb cancelled", 32'(rx), 32'h0);

        repeat (4) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule